// File: doc/BRIEF.md
# Parallel RGB Display Output Formatter

This block drives a 24-line parallel RGB display port from a 24-bit pixel stream. Each pixel arrives with horizontal sync, vertical sync and data-enable, all sampled on the pixel clock. The block first swaps the three colour channels in one of four ways. It then places the result on the 24 output lines in one of several bus layouts. A layout may carry 5/6/6/5 or 6/6/6 colour, with zero padding at fixed positions, or full 8/8/8 colour.

The block drives three control lines: horizontal sync, vertical sync and output-enable. Each one has its own polarity invert, its own option to launch on the falling clock edge, and its own disable. The output-enable line carries either data-enable or a composite sync built from both sync inputs. The forwarded pixel clock can also be inverted.

Software reaches the block through one control register at address 0. Every other address reads back a fixed identifier. Bit 0 of the control register switches the whole output on and off. Each time that bit goes from 0 to 1, the pipeline is restarted from a clean state.

Top module: `rgb_bus_formatter`

## Requirements
- R1: After reset the control register reads 0 and every output, including the forwarded clock, is low. While control bit 0 (enable) is 0, all outputs stay low whatever the pixel inputs do.
- R2: A write to address 0 loads control bits 16:0. A read of address 0 returns those bits, with bits 31:17 reading 0. A write to any other address leaves the control register unchanged.
- R3: A read of any address other than 0 returns 32'h0064_7069.
- R4: Control bits 15:14 choose the channel order. The input R is pix_rgb[23:16], G is [15:8] and B is [7:0]. The three channels that feed the packer, in the order R,G,B, are: code 0 gives R,G,B; code 1 gives B,G,R; code 2 gives G,R,B; code 3 gives B,R,G.
- R5: Control bits 13:11 choose the packing. A narrower channel takes the top bits of its 8-bit value. Each layout below is listed from out_data[23] down to bit 0. Code 1 is 8 zeros, R5, G6, B5. Code 2 is 3 zeros, R5, 2 zeros, G6, 3 zeros, B5. Code 3 is 2 zeros, R5, 3 zeros, G6, 2 zeros, B5, 1 zero.
- R6: Packing code 4 is 6 zeros, R6, G6, B6. Code 5 is 2 zeros, R6, 2 zeros, G6, 2 zeros, B6. Code 6 is R8, G8, B8. Codes 0 and 7 drive all 24 lines to zero.
- R7: A pixel and its control inputs sampled on one rising clock edge appear together on the rising-launched outputs at that same edge. This gives one cycle of latency and keeps data and control aligned.
- R8: Bit 10 inverts out_pclk. Bit 9 inverts hsync, bit 8 inverts vsync and bit 7 inverts output-enable.
- R9: Bit 3 disables hsync, bit 2 disables vsync and bit 1 disables output-enable. A disabled line sits at its inactive level, which is 0 without inversion and 1 with inversion.
- R10: Bit 6 launches hsync, bit 5 launches vsync and bit 4 launches output-enable on the falling clock edge. A line launched this way changes half a cycle after the rising edge that sampled its input.
- R11: With bit 16 set, the output-enable line carries data-enable. With bit 16 clear, it carries the composite sync, hsync OR vsync, before inversion.
- R12: On the first rising edge after the enable bit turns from 0 to 1, the pipeline is flushed. Outputs stay low through that edge, and the first pixel shown is the one sampled on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational from reg_addr |
| pix_rgb | input | 24 | Input pixel, R in bits 23:16, B in bits 7:0 |
| pix_hs | input | 1 | Input horizontal sync, active high |
| pix_vs | input | 1 | Input vertical sync, active high |
| pix_de | input | 1 | Input data-enable |
| out_pclk | output | 1 | Forwarded pixel clock, optionally inverted |
| out_data | output | 24 | Packed pixel lines |
| out_hs | output | 1 | Horizontal sync line |
| out_vs | output | 1 | Vertical sync line |
| out_en | output | 1 | Output-enable or composite sync line |

## Verification
A pixel driven two nanoseconds after rising edge K is sampled at edge K+1. From there it reaches the rising-launched lines at K+1 and the falling-launched lines half a period later. The scoreboard therefore tags each expected item with cycle K+1 and compares it six nanoseconds after that edge, by which time both launch styles have settled. Two further kinds of check are timed inside the half cycle. One looks one nanosecond after the edge to show that a falling-launched line still holds its old level. The other looks at out_pclk in both clock phases. Register reads are combinational and are checked one nanosecond after the address is set. Across a restart, the first edge after the enable write is expected to show zeros.

// File: rtl/rgbfmt_pkg.sv
`timescale 1ns/1ps
package rgbfmt_pkg;

  localparam int CH_W   = 8;
  localparam int PIX_W  = 3 * CH_W;
  localparam int CTRL_W = 17;
  localparam logic [31:0] FMT_ID = 32'h0064_7069;

  typedef enum logic [1:0] {
    ORD_RGB = 2'd0,
    ORD_BGR = 2'd1,
    ORD_GRB = 2'd2,
    ORD_BRG = 2'd3
  } order_e;

  typedef enum logic [2:0] {
    PK_ZERO   = 3'd0,
    PK_565_LO = 3'd1,
    PK_565_SP = 3'd2,
    PK_565_MD = 3'd3,
    PK_666_LO = 3'd4,
    PK_666_SP = 3'd5,
    PK_888    = 3'd6,
    PK_RSVD   = 3'd7
  } pack_e;

  // Field order matches the control word, bit 16 first.
  typedef struct packed {
    logic   oe_mode;
    order_e order;
    pack_e  pack;
    logic   pclk_inv;
    logic   hs_inv;
    logic   vs_inv;
    logic   oe_inv;
    logic   hs_fall;
    logic   vs_fall;
    logic   oe_fall;
    logic   hs_dis;
    logic   vs_dis;
    logic   oe_dis;
    logic   en;
  } ctrl_t;

  function automatic logic [PIX_W-1:0] reorder_px(input logic [PIX_W-1:0] px,
                                                  input order_e ord);
    logic [CH_W-1:0] r, g, b;
    r = px[3*CH_W-1:2*CH_W];
    g = px[2*CH_W-1:CH_W];
    b = px[CH_W-1:0];
    case (ord)
      ORD_BGR: reorder_px = {b, g, r};
      ORD_GRB: reorder_px = {g, r, b};
      ORD_BRG: reorder_px = {b, r, g};
      default: reorder_px = {r, g, b};
    endcase
  endfunction

  function automatic logic [PIX_W-1:0] pack_px(input logic [PIX_W-1:0] px,
                                               input pack_e code);
    logic [CH_W-1:0] r, g, b;
    r = px[3*CH_W-1:2*CH_W];
    g = px[2*CH_W-1:CH_W];
    b = px[CH_W-1:0];
    case (code)
      PK_565_LO: pack_px = {8'b0, r[7:3], g[7:2], b[7:3]};
      PK_565_SP: pack_px = {3'b0, r[7:3], 2'b0, g[7:2], 3'b0, b[7:3]};
      PK_565_MD: pack_px = {2'b0, r[7:3], 3'b0, g[7:2], 2'b0, b[7:3], 1'b0};
      PK_666_LO: pack_px = {6'b0, r[7:2], g[7:2], b[7:2]};
      PK_666_SP: pack_px = {2'b0, r[7:2], 2'b0, g[7:2], 2'b0, b[7:2]};
      PK_888:    pack_px = {r, g, b};
      default:   pack_px = '0;
    endcase
  endfunction

endpackage

// File: rtl/rgbfmt_regs.sv
`timescale 1ns/1ps
module rgbfmt_regs
  import rgbfmt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output ctrl_t             ctrl
);

  localparam int PAD_W = REG_W - CTRL_W;

  logic  hit_ctrl;
  logic  stray_wr;
  ctrl_t ctrl_q;

  assign hit_ctrl = (addr == '0);
  assign stray_wr = wr && !hit_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr && hit_ctrl)
      ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  assign ctrl  = ctrl_q;
  assign rdata = hit_ctrl ? {{PAD_W{1'b0}}, ctrl_q} : REG_W'(FMT_ID);

  AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    stray_wr |=> $stable(ctrl_q)); // R2

endmodule

// File: rtl/rgbfmt_pixel_path.sv
`timescale 1ns/1ps
module rgbfmt_pixel_path
  import rgbfmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  order_e           order,
  input  pack_e            pack,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] data_q
);

  logic [PIX_W-1:0] shuffled;
  logic [PIX_W-1:0] packed_px;
  logic             zero_code;
  logic             straight;

  assign shuffled  = reorder_px(pix_in, order);
  assign packed_px = pack_px(shuffled, pack);
  assign zero_code = (pack == PK_ZERO) || (pack == PK_RSVD);
  assign straight  = (pack == PK_888) && (order == ORD_RGB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (flush) data_q <= '0;
    else            data_q <= packed_px;
  end

  AST_ZERO_CODE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    zero_code |=> (data_q == '0)); // R6

  AST_FULL_WIDTH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && straight) |=> (data_q == $past(pix_in))); // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (data_q == '0)); // R12

endmodule

// File: rtl/rgbfmt_sync_lane.sv
`timescale 1ns/1ps
module rgbfmt_sync_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic raw,
  input  logic inv,
  input  logic fall,
  input  logic dis,
  output logic lane_out
);

  logic level;
  logic launch;
  logic rise_q;
  logic fall_q;

  assign level  = dis ? 1'b0 : raw;
  assign launch = level ^ inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rise_q <= 1'b0;
    else if (flush) rise_q <= 1'b0;
    else            rise_q <= launch;
  end

  // Retimes the rising-edge value by half a cycle.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)     fall_q <= 1'b0;
    else if (flush) fall_q <= 1'b0;
    else            fall_q <= rise_q;
  end

  assign lane_out = fall ? fall_q : rise_q;

  AST_LANE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !dis) |=> (rise_q == ($past(raw) ^ $past(inv)))); // R7

  AST_DISABLED_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && dis) |=> (rise_q == $past(inv))); // R9

  AST_FALL_HALF_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (fall_q == rise_q)); // R10

endmodule

// File: rtl/rgb_bus_formatter.sv
`timescale 1ns/1ps
module rgb_bus_formatter
  import rgbfmt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [23:0]       pix_rgb,
  input  logic              pix_hs,
  input  logic              pix_vs,
  input  logic              pix_de,
  output logic              out_pclk,
  output logic [23:0]       out_data,
  output logic              out_hs,
  output logic              out_vs,
  output logic              out_en
);

  localparam int N_LANE = 3;

  ctrl_t             ctrl;
  logic              en_prev;
  logic              start_pulse;
  logic              flush;
  logic [PIX_W-1:0]  data_q;
  logic [N_LANE-1:0] lane_raw, lane_inv, lane_fall, lane_dis, lane_out;

  rgbfmt_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctrl  (ctrl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev <= 1'b0;
    else        en_prev <= ctrl.en;
  end

  assign start_pulse = ctrl.en && !en_prev;
  assign flush       = !ctrl.en || start_pulse;

  rgbfmt_pixel_path u_pix (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .order  (ctrl.order),
    .pack   (ctrl.pack),
    .pix_in (pix_rgb),
    .data_q (data_q)
  );

  // Lane 0 is hsync, lane 1 is vsync, lane 2 is output-enable.
  assign lane_raw  = {ctrl.oe_mode ? pix_de : (pix_hs | pix_vs), pix_vs, pix_hs};
  assign lane_inv  = {ctrl.oe_inv,  ctrl.vs_inv,  ctrl.hs_inv};
  assign lane_fall = {ctrl.oe_fall, ctrl.vs_fall, ctrl.hs_fall};
  assign lane_dis  = {ctrl.oe_dis,  ctrl.vs_dis,  ctrl.hs_dis};

  for (genvar i = 0; i < N_LANE; i++) begin : g_lane
    rgbfmt_sync_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .raw      (lane_raw[i]),
      .inv      (lane_inv[i]),
      .fall     (lane_fall[i]),
      .dis      (lane_dis[i]),
      .lane_out (lane_out[i])
    );
  end

  assign out_data = {PIX_W{ctrl.en}} & data_q;
  assign out_hs   = ctrl.en & lane_out[0];
  assign out_vs   = ctrl.en & lane_out[1];
  assign out_en   = ctrl.en & lane_out[2];
  assign out_pclk = ctrl.en & (clk ^ ctrl.pclk_inv);

  AST_OFF_PIPE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> (data_q == '0)); // R1

  AST_RESTART_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> ((out_data == '0) && !out_hs && !out_vs && !out_en)); // R12

endmodule

// File: tb/tb_rgb_bus_formatter.sv
`timescale 1ns/1ps
module tb_rgb_bus_formatter;

  localparam real TCK = 8.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [23:0] pix_rgb = '0;
  logic        pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
  logic        out_pclk, out_hs, out_vs, out_en;
  logic [23:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  logic [16:0] cfg = '0;

  typedef struct {
    int          due;
    logic [26:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #(TCK/2) clk = ~clk;

  rgb_bus_formatter dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_rgb(pix_rgb),
    .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de), .out_pclk(out_pclk),
    .out_data(out_data), .out_hs(out_hs), .out_vs(out_vs), .out_en(out_en)
  );

  function automatic logic [23:0] chan_bits(logic [7:0] v, int keep, int pos);
    logic [23:0] w;
    w = 24'(v >> (8 - keep));
    return w << pos;
  endfunction

  function automatic logic [26:0] model(logic [16:0] c, logic [23:0] px,
                                        logic hs, logic vs, logic de);
    logic [7:0] r, g, b, a, m, z;
    logic [23:0] d;
    logic h, v, o, src;
    r = px[23:16]; g = px[15:8]; b = px[7:0];
    case (c[15:14])
      2'd1:    begin a = b; m = g; z = r; end
      2'd2:    begin a = g; m = r; z = b; end
      2'd3:    begin a = b; m = r; z = g; end
      default: begin a = r; m = g; z = b; end
    endcase
    case (c[13:11])
      3'd1: d = chan_bits(a,5,11) | chan_bits(m,6,5)  | chan_bits(z,5,0);
      3'd2: d = chan_bits(a,5,16) | chan_bits(m,6,8)  | chan_bits(z,5,0);
      3'd3: d = chan_bits(a,5,17) | chan_bits(m,6,8)  | chan_bits(z,5,1);
      3'd4: d = chan_bits(a,6,12) | chan_bits(m,6,6)  | chan_bits(z,6,0);
      3'd5: d = chan_bits(a,6,16) | chan_bits(m,6,8)  | chan_bits(z,6,0);
      3'd6: d = chan_bits(a,8,16) | chan_bits(m,8,8)  | chan_bits(z,8,0);
      default: d = '0;
    endcase
    src = c[16] ? de : (hs | vs);
    h = c[3] ? c[9] : (hs ^ c[9]);
    v = c[2] ? c[8] : (vs ^ c[8]);
    o = c[1] ? c[7] : (src ^ c[7]);
    if (!c[0]) return '0;
    return {d, h, v, o};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares due items 6 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #6;
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        check(it.tag, {5'b0, out_data, out_hs, out_vs, out_en}, {5'b0, it.exp});
      end
    end
  end

  task automatic drive(logic [23:0] px, logic hs, logic vs, logic de, string tag);
    @(posedge clk); #2;
    pix_rgb = px; pix_hs = hs; pix_vs = vs; pix_de = de;
    q.push_back('{cyc + 1, model(cfg, px, hs, vs, de), tag});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0; reg_addr = '0;
    if (a == 8'h00) cfg = d[16:0];
  endtask

  task automatic rd_check(logic [7:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #2;
    reg_addr = a;
    #1 check(tag, reg_rdata, exp);
    reg_addr = '0;
  endtask

  task automatic stream(string tag);
    drive(24'hA5C3E7, 1'b0, 1'b0, 1'b1, tag);
    drive(24'h8C4A29, 1'b1, 1'b0, 1'b0, tag);
    drive(24'hFFFFFF, 1'b0, 1'b1, 1'b1, tag);
    drive(24'h123456, 1'b1, 1'b1, 1'b0, tag);
    drive(24'h000000, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(TCK * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R7 pipeline never drained actual=running expected=done");
    finish_run();
  end

  localparam logic [16:0] EN = 17'h00001, MODE = 17'h10000, PK6 = 17'h03000;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    check("R1 reset outputs", {5'b0, out_data, out_hs, out_vs, out_en}, '0);
    check("R1 reset pclk", {31'b0, out_pclk}, '0);
    rd_check(8'h00, 32'h0, "R1 reset ctrl");
    rd_check(8'h04, 32'h0064_7069, "R3 id at 4");
    rd_check(8'hFC, 32'h0064_7069, "R3 id at FC");

    wr(8'h00, 32'hFFFF_FFFE);
    rd_check(8'h00, 32'h0001_FFFE, "R2 readback");
    wr(8'h08, 32'h0000_0001);
    rd_check(8'h00, 32'h0001_FFFE, "R2 stray write");
    rd_check(8'h10, 32'h0064_7069, "R3 id at 10");
    stream("R1 disabled");
    @(posedge clk); #1 check("R1 pclk off", {31'b0, out_pclk}, '0);

    // Restart: the first edge after enabling is flushed.
    wr(8'h00, 32'(EN | MODE | PK6));
    pix_rgb = 24'hA5C3E7; pix_hs = 1'b1; pix_vs = 1'b1; pix_de = 1'b1;
    q.push_back('{cyc + 1, 27'h0, "R12 restart flush"});
    stream("R7 aligned");

    for (int o = 0; o < 4; o++) begin
      wr(8'h00, 32'(EN | MODE | PK6 | (17'(o) << 14)));
      stream("R4 order");
    end

    for (int p = 0; p < 8; p++) begin
      wr(8'h00, 32'(EN | MODE | (17'(p) << 11) | (17'(p & 1) << 14)));
      stream((p >= 1 && p <= 3) ? "R5 pack565" : "R6 pack");
    end

    wr(8'h00, 32'(EN | MODE | PK6 | 17'h00780));
    stream("R8 invert");
    @(posedge clk); #1 check("R8 pclk inv high phase", {31'b0, out_pclk}, 32'h0);
    #4 check("R8 pclk inv low phase", {31'b0, out_pclk}, 32'h1);
    wr(8'h00, 32'(EN | MODE | PK6));
    @(posedge clk); #1 check("R8 pclk plain high phase", {31'b0, out_pclk}, 32'h1);

    wr(8'h00, 32'(EN | MODE | PK6 | 17'h0020E));
    stream("R9 disable inv hs");
    wr(8'h00, 32'(EN | MODE | PK6 | 17'h0000E));
    stream("R9 disable plain");

    wr(8'h00, 32'(EN | PK6));
    stream("R11 composite");
    wr(8'h00, 32'(EN | PK6 | 17'h00080));
    stream("R11 composite inv");

    wr(8'h00, 32'(EN | MODE | PK6 | 17'h00070));
    drive(24'h010203, 1'b0, 1'b0, 1'b0, "R10 fall");
    drive(24'h040506, 1'b1, 1'b1, 1'b1, "R10 fall");
    @(posedge clk); #1;
    check("R10 fall lines still old", {29'b0, out_hs, out_vs, out_en}, 32'h0);
    check("R10 rise data already new", {8'b0, out_data}, 32'h040506);
    stream("R10 fall");

    wr(8'h00, 32'h0);
    stream("R1 off again");

    repeat (4) @(posedge clk);
    wait (q.size() == 0);
    #1;
    finish_run();
  end

endmodule